// File: doc/BRIEF.md
# Interrupt Priority and Stacking Sequencer

This block sits beside a small 8-bit CPU core. It decides which interrupt to take when an instruction finishes, and it performs the memory traffic for interrupt entry and return. When the core signals that an instruction has finished, the block looks at the hardware requests, the current interrupt mask and two decode strobes, one for a software-interrupt opcode and one for a return opcode. It then runs one of three sequences. Entry saves five register bytes to a small descending stack, then reads a two-byte vector. Return reads the five bytes back. The third case leaves everything alone.

The core presents its program counter, index register, accumulator and condition code register on input ports. When a sequence ends, the block presents the new values on its output ports together with a one-cycle load strobe. The stack lives in a fixed 64-byte window at addresses $C0 to $FF. A 6-bit pointer addresses it, so the pointer wraps inside that window. The memory port is synchronous: read data arrives on the cycle after the read address. While a sequence is running, `ready` is low and the core must not fetch.

Top module: `isq_sequencer`

## Requirements
- R1: While reset is high, `ready` is low. After release, the block reads the reset vector: the high byte from $1FFE and the low byte from $1FFF. It then raises `ready` with `reg_load` in the third cycle after release. The loaded PC is the low 13 bits of {high, low}. The condition code output is 8'h08, with the interrupt mask in bit 3. X and A load as zero, and the stack pointer starts at 63 (address $FF).
- R2: An entry makes five consecutive writes, starting in the cycle after the boundary. The order is: PC low byte at SP, PC high byte (zero-extended to 8 bits) at SP-1, X at SP-2, A at SP-3, and the unmodified condition code byte at SP-4. SP ends 5 lower.
- R3: After the writes, the vector is read high byte first, then low byte. Hardware sources are indexed by `hw_req` bit 0 to bit 3, and a lower bit wins. Bit 0 uses $1FFA, bit 1 uses $1FF8, bit 2 uses $1FF6 and bit 3 uses $1FF4.
- R4: When `ccr_in` bit 3 is set, hardware requests cause no sequence at a boundary.
- R5: A software-interrupt strobe at a boundary starts an entry through $1FFC whatever the state of `ccr_in` bit 3.
- R6: When a software-interrupt strobe and an unmasked hardware request arrive at the same boundary, the hardware entry is taken instead.
- R7: `hw_ack` is one-hot for exactly one cycle, the first write cycle of a hardware entry, and names the chosen source. It stays zero for software entries.
- R8: A return reads SP+1 to SP+5 on five consecutive cycles and restores, in that order, the condition code register, A, X, the PC high byte and the PC low byte. SP ends 5 higher.
- R9: The stack pointer is 6 bits wide and its addresses are always $C0 to $FF. A push below $C0 continues at $FF, and a pop above $FF continues at $C0.
- R10: `ready` is low for 8 cycles during an entry and for 6 cycles during a return. `reg_load` pulses in the first ready cycle. A strobe that arrives while `ready` is low is ignored.
- R11: A boundary with no qualifying request, or any cycle without `insn_done`, leaves `ready` high and the memory port idle.
- R12: After an entry, `ccr_out` equals the captured condition code byte with bit 3 set. `x_out` and `a_out` equal the captured X and A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | N_HW | Pending hardware requests, bit 0 highest |
| swi_op | input | 1 | Software-interrupt opcode decoded |
| rti_op | input | 1 | Return-from-interrupt opcode decoded |
| insn_done | input | 1 | Current instruction has completed |
| pc_in | input | ADDR_W | Program counter to be saved |
| x_in | input | 8 | Index register to be saved |
| a_in | input | 8 | Accumulator to be saved |
| ccr_in | input | 8 | Condition codes; bit 3 is the interrupt mask |
| mem_addr | output | ADDR_W | Memory address |
| mem_re | output | 1 | Read request; data valid next cycle |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |
| pc_out | output | ADDR_W | New program counter |
| x_out | output | 8 | New index register |
| a_out | output | 8 | New accumulator |
| ccr_out | output | 8 | New condition codes |
| reg_load | output | 1 | One-cycle strobe: register outputs valid |
| hw_ack | output | N_HW | One-hot acknowledge to the chosen hardware source |
| ready | output | 1 | Idle; the core may fetch |

## Verification
The properties assume that `insn_done` and the two opcode strobes are one-cycle pulses presented only while `ready` is high. They also assume that `mem_rdata` returns the byte addressed on the previous cycle. The stimulus holds every strobe for exactly one cycle. It also puts a strobe inside a busy window on purpose, to confirm that the design ignores it. A behavioural memory answers each read one cycle later. Requests are cleared after each boundary, so the properties never see a request that changes while a sequence is running.

// File: rtl/isq_pkg.sv
`timescale 1ns/1ps
package isq_pkg;
  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_VEC, S_POP} isq_state_e;
  localparam int IMASK_BIT = 3;
  localparam int PUSH_LAST = 4;
  localparam int POP_LAST  = 5;
endpackage

// File: rtl/isq_arbiter.sv
`timescale 1ns/1ps
module isq_arbiter #(
  parameter int N_HW = 4
) (
  input  logic [N_HW-1:0]             hw_req,
  input  logic                        swi_op,
  input  logic                        rti_op,
  input  logic                        insn_done,
  input  logic                        ready,
  input  logic                        i_mask,
  output logic                        take_entry,
  output logic                        take_pop,
  output logic [$clog2(N_HW+2)-1:0]   sel_idx,
  output logic [N_HW-1:0]             ack_vec
);
  localparam int IDX_W = $clog2(N_HW+2);

  logic             hit;
  logic             take_hw;
  logic             boundary;
  logic [IDX_W-1:0] hw_idx;

  // Lower request index is the higher priority; vector index 0 is reset, 1 is software.
  always_comb begin
    hit    = 1'b0;
    hw_idx = '0;
    for (int k = N_HW - 1; k >= 0; k--) begin
      if (hw_req[k]) begin
        hit    = 1'b1;
        hw_idx = IDX_W'(k + 2);
      end
    end
    boundary   = insn_done && ready;
    take_pop   = boundary && rti_op;
    take_hw    = boundary && !rti_op && hit && !i_mask;
    take_entry = take_hw || (boundary && !rti_op && swi_op);
    sel_idx    = take_hw ? hw_idx : IDX_W'(1);
  end

  generate
    for (genvar g = 0; g < N_HW; g++) begin : g_ack
      assign ack_vec[g] = take_hw && (hw_idx == IDX_W'(g + 2));
    end
  endgenerate
endmodule

// File: rtl/isq_stack_ptr.sv
`timescale 1ns/1ps
module isq_stack_ptr #(
  parameter int SP_W   = 6,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] pop_addr
);
  localparam int HI_W = ADDR_W - SP_W - 2;

  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] sp_up;

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '1;
    else if (push) sp_q <= sp_q - SP_W'(1);
    else if (pop)  sp_q <= sp_q + SP_W'(1);
  end

  assign sp_up     = sp_q + SP_W'(1);
  assign push_addr = {{HI_W{1'b0}}, 2'b11, sp_q};
  assign pop_addr  = {{HI_W{1'b0}}, 2'b11, sp_up};
endmodule

// File: rtl/isq_sequencer.sv
`timescale 1ns/1ps
module isq_sequencer #(
  parameter int          ADDR_W  = 13,
  parameter int          N_HW    = 4,
  parameter int          SP_W    = 6,
  parameter logic [15:0] VEC_TOP = 16'h1FFE,
  parameter logic [7:0]  RST_CCR = 8'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_HW-1:0]   hw_req,
  input  logic              swi_op,
  input  logic              rti_op,
  input  logic              insn_done,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [7:0]        x_in,
  input  logic [7:0]        a_in,
  input  logic [7:0]        ccr_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] pc_out,
  output logic [7:0]        x_out,
  output logic [7:0]        a_out,
  output logic [7:0]        ccr_out,
  output logic              reg_load,
  output logic [N_HW-1:0]   hw_ack,
  output logic              ready
);
  import isq_pkg::*;
  localparam int IDX_W = $clog2(N_HW+2);

  isq_state_e       state_q;
  logic [2:0]       step_q;
  logic [IDX_W-1:0] vidx_q;
  logic [ADDR_W-1:0] pc_q;
  logic [7:0]       x_q, a_q, ccr_q, hi_q;
  logic             load_q;
  logic [N_HW-1:0]  ack_q;

  logic             take_entry, take_pop;
  logic [IDX_W-1:0] sel_idx;
  logic [N_HW-1:0]  ack_vec;
  logic [ADDR_W-1:0] push_addr, pop_addr, vec_base;
  logic [15:0]      pc_ext;
  logic             sp_dec, sp_inc;

  assign ready = (state_q == S_IDLE);

  isq_arbiter #(.N_HW(N_HW)) u_arb (
    .hw_req(hw_req), .swi_op(swi_op), .rti_op(rti_op), .insn_done(insn_done),
    .ready(ready), .i_mask(ccr_in[IMASK_BIT]), .take_entry(take_entry),
    .take_pop(take_pop), .sel_idx(sel_idx), .ack_vec(ack_vec)
  );

  assign sp_dec = (state_q == S_PUSH);
  assign sp_inc = (state_q == S_POP) && (step_q < 3'(POP_LAST));

  isq_stack_ptr #(.SP_W(SP_W), .ADDR_W(ADDR_W)) u_sp (
    .clk(clk), .rst(rst), .push(sp_dec), .pop(sp_inc),
    .push_addr(push_addr), .pop_addr(pop_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_VEC;
      step_q  <= '0;
      vidx_q  <= '0;
      pc_q    <= '0;
      x_q     <= '0;
      a_q     <= '0;
      ccr_q   <= RST_CCR;
      hi_q    <= '0;
      load_q  <= 1'b0;
      ack_q   <= '0;
    end else begin
      load_q <= 1'b0;
      ack_q  <= '0;
      unique case (state_q)
        S_IDLE: begin
          step_q <= '0;
          if (take_pop) begin
            state_q <= S_POP;
          end else if (take_entry) begin
            state_q <= S_PUSH;
            vidx_q  <= sel_idx;
            pc_q    <= pc_in;
            x_q     <= x_in;
            a_q     <= a_in;
            ccr_q   <= ccr_in;
            ack_q   <= ack_vec;
          end
        end
        S_PUSH: begin
          step_q <= step_q + 3'd1;
          if (step_q == 3'(PUSH_LAST)) begin
            state_q <= S_VEC;
            step_q  <= '0;
          end
        end
        S_VEC: begin
          step_q <= step_q + 3'd1;
          if (step_q == 3'd1) hi_q <= mem_rdata;
          if (step_q == 3'd2) begin
            pc_q             <= ADDR_W'({hi_q, mem_rdata});
            ccr_q[IMASK_BIT] <= 1'b1;
            load_q           <= 1'b1;
            state_q          <= S_IDLE;
          end
        end
        S_POP: begin
          step_q <= step_q + 3'd1;
          case (step_q)
            3'd1: ccr_q <= mem_rdata;
            3'd2: a_q   <= mem_rdata;
            3'd3: x_q   <= mem_rdata;
            3'd4: hi_q  <= mem_rdata;
            3'd5: begin
              pc_q    <= ADDR_W'({hi_q, mem_rdata});
              load_q  <= 1'b1;
              state_q <= S_IDLE;
            end
            default: ;
          endcase
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pc_ext   = 16'(pc_q);
  assign vec_base = ADDR_W'(VEC_TOP) - (ADDR_W'(vidx_q) << 1);

  always_comb begin
    mem_we    = (state_q == S_PUSH);
    mem_re    = ((state_q == S_VEC) && (step_q < 3'd2)) ||
                ((state_q == S_POP) && (step_q < 3'(POP_LAST)));
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      S_PUSH:  mem_addr = push_addr;
      S_POP:   mem_addr = pop_addr;
      S_VEC:   mem_addr = vec_base + ADDR_W'(step_q[0]);
      default: mem_addr = '0;
    endcase
    if (state_q == S_PUSH) begin
      case (step_q)
        3'd0:    mem_wdata = pc_ext[7:0];
        3'd1:    mem_wdata = pc_ext[15:8];
        3'd2:    mem_wdata = x_q;
        3'd3:    mem_wdata = a_q;
        default: mem_wdata = ccr_q;
      endcase
    end
  end

  assign pc_out   = pc_q;
  assign x_out    = x_q;
  assign a_out    = a_q;
  assign ccr_out  = ccr_q;
  assign reg_load = load_q;
  assign hw_ack   = ack_q;
endmodule

// File: rtl/isq_checker.sv
`timescale 1ns/1ps
module isq_checker #(
  parameter int ADDR_W = 13,
  parameter int N_HW   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              insn_done,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [N_HW-1:0]   hw_ack,
  input logic              reg_load
);
  assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hw_ack));

  assert_ack_on_push_R2: assert property (@(posedge clk) disable iff (rst)
    (|hw_ack) |-> (mem_we && mem_addr[7:6] == 2'b11));

  assert_stack_window_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[ADDR_W-1:8] == '0 && mem_addr[7:6] == 2'b11));

  assert_idle_port_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!mem_we && !mem_re));

  assert_idle_stays_R11: assert property (@(posedge clk) disable iff (rst)
    (ready && !insn_done) |=> ready);

  assert_load_at_finish_R10: assert property (@(posedge clk) disable iff (rst)
    reg_load |-> (ready && $past(!ready)));

  assert_rw_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
endmodule

bind isq_sequencer isq_checker #(.ADDR_W(ADDR_W), .N_HW(N_HW)) u_isq_chk (
  .clk(clk), .rst(rst), .ready(ready), .insn_done(insn_done),
  .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
  .hw_ack(hw_ack), .reg_load(reg_load)
);

// File: tb/isq_sequencer_test.sv
`timescale 1ns/1ps
module isq_sequencer_test;
  localparam int AW = 13;
  localparam int NH = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic [NH-1:0] hw_req = '0;
  logic          swi_op = 1'b0, rti_op = 1'b0, insn_done = 1'b0;
  logic [AW-1:0] pc_in = '0;
  logic [7:0]    x_in = '0, a_in = '0, ccr_in = '0;
  logic [AW-1:0] mem_addr, pc_out;
  logic          mem_re, mem_we, reg_load, ready;
  logic [7:0]    mem_wdata, x_out, a_out, ccr_out;
  logic [7:0]    mem_rdata = '0;
  logic [NH-1:0] hw_ack;

  isq_sequencer uut (
    .clk(clk), .rst(rst), .hw_req(hw_req), .swi_op(swi_op), .rti_op(rti_op),
    .insn_done(insn_done), .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .ccr_in(ccr_in),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pc_out(pc_out), .x_out(x_out), .a_out(a_out),
    .ccr_out(ccr_out), .reg_load(reg_load), .hw_ack(hw_ack), .ready(ready)
  );

  function automatic logic [7:0] vb(input logic [AW-1:0] ad);
    return ad[7:0] ^ 8'hA5;
  endfunction

  logic [7:0] stk [64];
  always @(posedge clk) begin
    if (mem_we) stk[mem_addr[5:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= (mem_addr[AW-1:8] != '0) ? vb(mem_addr) : stk[mem_addr[5:0]];
  end

  typedef struct {
    bit rdy; bit we; bit re; logic [AW-1:0] addr; logic [7:0] wd;
    logic [NH-1:0] ack; bit load; logic [AW-1:0] pc; logic [7:0] x, a, c; string tag;
  } exp_t;

  exp_t q[$];
  logic [7:0] mstk [64];
  logic [5:0] msp = 6'h3F;
  int  checks = 0, fails = 0, seq = 0;
  bit  cur_ready = 1'b0, finished = 1'b0;

  function automatic exp_t mk(bit rdy, bit we, bit re, logic [AW-1:0] ad,
                              logic [7:0] wd, logic [NH-1:0] ack, string tag);
    exp_t e;
    e.rdy = rdy; e.we = we; e.re = re; e.addr = ad; e.wd = wd; e.ack = ack;
    e.load = 1'b0; e.pc = '0; e.x = '0; e.a = '0; e.c = '0; e.tag = tag;
    return e;
  endfunction

  function automatic logic [AW-1:0] saddr(logic [5:0] p);
    return {5'b0, 2'b11, p};
  endfunction

  task automatic push_final(logic [AW-1:0] pc, logic [7:0] x, logic [7:0] a,
                            logic [7:0] c, string tag);
    exp_t e = mk(1, 0, 0, '0, '0, '0, tag);
    e.load = 1'b1; e.pc = pc; e.x = x; e.a = a; e.c = c;
    q.push_back(e);
  endtask

  task automatic tick();
    exp_t e;
    bit ok;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else e = mk(1, 0, 0, '0, '0, '0, "R11 idle");
    ok = (ready == e.rdy) && (mem_we == e.we) && (mem_re == e.re) &&
         (hw_ack == e.ack) && (reg_load == e.load);
    if (e.we || e.re) ok = ok && (mem_addr == e.addr);
    if (e.we) ok = ok && (mem_wdata == e.wd);
    if (e.load) ok = ok && (pc_out == e.pc) && (x_out == e.x) &&
                     (a_out == e.a) && (ccr_out == e.c);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got rdy=%b we=%b re=%b addr=%h wd=%h ack=%b load=%b pc=%h x=%h a=%h c=%h | exp rdy=%b we=%b re=%b addr=%h wd=%h ack=%b load=%b pc=%h x=%h a=%h c=%h",
               e.tag, ready, mem_we, mem_re, mem_addr, mem_wdata, hw_ack, reg_load,
               pc_out, x_out, a_out, ccr_out, e.rdy, e.we, e.re, e.addr, e.wd, e.ack,
               e.load, e.pc, e.x, e.a, e.c);
    end
    cur_ready = e.rdy;
  endtask

  task automatic model_entry(int idx, logic [NH-1:0] ack, string tag);
    logic [7:0] bytes [5];
    logic [AW-1:0] va;
    logic [15:0] pe;
    pe = 16'(pc_in);
    bytes[0] = pe[7:0]; bytes[1] = pe[15:8]; bytes[2] = x_in; bytes[3] = a_in; bytes[4] = ccr_in;
    for (int k = 0; k < 5; k++) begin
      logic [5:0] p = msp - 6'(k);
      q.push_back(mk(0, 1, 0, saddr(p), bytes[k], (k == 0) ? ack : '0, {tag, " R2 push"}));
      mstk[p] = bytes[k];
    end
    msp = msp - 6'd5;
    va = AW'(16'h1FFE - 16'(2 * idx));
    q.push_back(mk(0, 0, 1, va, '0, '0, {tag, " R3 vec hi"}));
    q.push_back(mk(0, 0, 1, va + 1'b1, '0, '0, {tag, " R3 vec lo"}));
    q.push_back(mk(0, 0, 0, '0, '0, '0, {tag, " R10 busy"}));
    push_final(AW'({vb(va), vb(va + 1'b1)}), x_in, a_in, ccr_in | 8'h08, {tag, " R12 load"});
  endtask

  task automatic model_pop(string tag);
    for (int k = 1; k <= 5; k++)
      q.push_back(mk(0, 0, 1, saddr(msp + 6'(k)), '0, '0, {tag, " R8 pop"}));
    q.push_back(mk(0, 0, 0, '0, '0, '0, {tag, " R10 busy"}));
    push_final(AW'({mstk[msp + 6'd4], mstk[msp + 6'd5]}), mstk[msp + 6'd3],
               mstk[msp + 6'd2], mstk[msp + 6'd1], {tag, " R8 restore"});
    msp = msp + 6'd5;
  endtask

  task automatic boundary(bit swi, bit rti, logic [NH-1:0] hw, logic [7:0] ccr, string tag);
    seq++;
    insn_done = 1'b1; swi_op = swi; rti_op = rti; hw_req = hw; ccr_in = ccr;
    pc_in = AW'(13'h0A00 + seq * 37); x_in = 8'(seq * 11 + 3); a_in = 8'(seq * 29 + 7);
    if (cur_ready) begin
      if (rti) model_pop(tag);
      else if (!ccr[3] && hw != '0) begin
        int w = 0;
        for (int k = NH - 1; k >= 0; k--) if (hw[k]) w = k;
        model_entry(w + 2, NH'(1) << w, tag);
      end else if (swi) model_entry(1, '0, tag);
    end
    tick();
    insn_done = 1'b0; swi_op = 1'b0; rti_op = 1'b0; hw_req = '0;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mstk[k] = 8'h00;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (ready !== 1'b0) begin
        fails++;
        $display("FAIL R1 reset: ready=%b expected 0", ready);
      end
    end
    rst = 1'b0;
    q.push_back(mk(0, 0, 1, 13'h1FFF, '0, '0, "R1 reset vec lo"));
    q.push_back(mk(0, 0, 0, '0, '0, '0, "R1 reset busy"));
    push_final(AW'({vb(13'h1FFE), vb(13'h1FFF)}), 8'h00, 8'h00, 8'h08, "R1 reset load");
    idle(4);
    boundary(0, 0, '0, 8'h00, "R11 empty boundary");
    idle(2);
    boundary(0, 0, 4'b0001, 8'h00, "R7 irq entry");
    idle(10);
    boundary(0, 1, '0, 8'h08, "R8 return");
    idle(8);
    boundary(0, 0, 4'b1000, 8'h08, "R4 masked");
    idle(3);
    boundary(1, 0, '0, 8'h08, "R5 swi masked");
    idle(10);
    boundary(0, 0, 4'b1110, 8'h00, "R3 priority");
    idle(10);
    boundary(1, 0, 4'b1000, 8'h00, "R6 swi vs kbd");
    idle(2);
    boundary(0, 0, 4'b0001, 8'h00, "R10 ignored while busy");
    idle(10);
    for (int i = 0; i < 13; i++) begin
      boundary(0, 0, NH'(1) << (i % NH), 8'h00, "R9 deep push");
      idle(9);
    end
    for (int i = 0; i < 16; i++) begin
      boundary(0, 1, '0, 8'h00, "R9 deep pop");
      idle(7);
    end
    idle(3);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule